// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous 1024-row DRAM alive. After reset it waits out the power-up pause. It then runs a fixed number of initialization refresh cycles, and after that it schedules one distributed refresh for every slice of the retention period. The refresh style is CAS-before-RAS. WE is held high throughout, so the part never sees a test-mode entry. A parameter can switch the block to RAS-only refresh, in which case the block also supplies the row address from its own counter.

The block shares the DRAM pins with an access controller. It raises `ref_req` when it has work. It waits for `ref_gnt`. While `bus_own` is high it drives the strobes itself. During initialization it keeps the bus from the first grant until the last initialization cycle ends, so no access can slip in before `init_done`. Refresh requests that arrive while the grant is withheld are counted, up to a ceiling. The whole backlog is then run back to back under one grant.

Every timing value is given in nanoseconds and converted to whole clock cycles, rounding up. The retention period is picked by a low-power parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset release, `ref_req`, RAS and CAS stay inactive for at least PAUSE_C = ceil(PAUSE_NS/CLK_NS) cycles. `ref_req` rises within two cycles after the pause ends.
- R2: Exactly INIT_REFRESH (default 8) refresh cycles, counted as RAS falling edges, happen before `init_done` rises. `init_done` rises in the cycle where the last one's precharge ends.
- R3: From the first grant until `init_done` rises, `bus_own` and `ref_req` stay high without a gap. In the cycle where `init_done` rises, both are low if no refresh is pending.
- R4: In CAS-before-RAS mode, CAS is low for at least CSR_C = ceil(T_CSR_NS/CLK_NS) cycles before RAS falls. It stays low for at least CHR_C = ceil(T_CHR_NS/CLK_NS) cycles after RAS falls.
- R5: While `bus_own` is high, `ram_we_n` is high. While `bus_own` is low, `ram_ras_n` and `ram_cas_n` are both high. All three strobes are high in reset.
- R6: RAS stays low for at least ACT_C = max(ceil(T_RAS_NS/CLK_NS), ceil((T_RC_NS-T_RP_NS)/CLK_NS)) cycles. RAS stays high for at least PRE_C = max(ceil(T_RP_NS/CLK_NS), ceil(T_CPN_NS/CLK_NS)) cycles before the next fall, so CAS is also high for that time.
- R7: With LOW_POWER=0 and the grant always given, `ref_req` rises every INTERVAL_C = NORMAL_RET_NS/ROWS/CLK_NS - GUARD_CYC cycles.
- R8: With LOW_POWER=1, the interval uses LP_RET_NS in place of NORMAL_RET_NS.
- R9: No RAS or CAS activity starts unless `ref_gnt` was high in the cycle before. While the grant is withheld, the block waits with `ref_req` high.
- R10: Refresh requests that arrive while the grant is withheld are counted up to MAX_PENDING (default 8); further requests are dropped. After the grant, the block runs min(waiting, MAX_PENDING) refreshes back to back without releasing the bus.
- R11: With ROR_EN=1, CAS stays high on every cycle. `ram_row` reads 0 on the first refresh and advances by one on each later refresh, wrapping from ROWS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh wants the DRAM pins |
| ref_gnt | input | 1 | Access controller hands over the pins; held until `ref_req` falls |
| bus_own | output | 1 | Block is driving the DRAM strobes |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, held high |
| ram_row | output | $clog2(ROWS) | Row address for RAS-only refresh; zero in CAS-before-RAS mode |
| init_done | output | 1 | Initialization finished; normal access may begin |

## Verification
The bench uses a short pause, short retention periods and a 16-row RAS-only variant. This brings every counter boundary within reach.

- **Pause and initialization.** A design that counted the pause one cycle short, or ran seven or nine initialization cycles, would show a request too early or a wrong RAS-edge count at `init_done`. A design that let go of the bus between initialization cycles would show a gap in `bus_own`.
- **Backlog.** The grant is withheld for one up to ten intervals. A backlog counter that wrapped instead of saturating would run too few cycles. One that released the bus after each cycle would break the back-to-back burst.
- **Strobe timing.** Pin monitors measure every CAS lead, CAS hold, RAS width and precharge gap. An off-by-one in any segment counter shows up there.
- **Row counter.** The RAS-only variant runs past its wrap point, so an off-by-one at ROWS-1 shows up as a wrong address.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_IDLE,
      ST_REQ,
      ST_LEAD,
      ST_ACT,
      ST_PRE
   } ref_state_t;

   // integer division rounded up, used to turn ns limits into cycles
   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
   parameter int PAUSE_C    = 20000,
   parameter int INTERVAL_C = 3105
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic pause_done,
   output logic tick
);
   localparam int PW = $clog2(PAUSE_C + 1);
   localparam int IW = $clog2(INTERVAL_C + 1);

   logic [PW-1:0] pause_q;
   logic [IW-1:0] ivl_q;

   // power-up pause: pause_done is set on edge number PAUSE_C after reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pause_q    <= '0;
         pause_done <= 1'b0;
      end else if (!pause_done) begin
         if (pause_q == PW'(PAUSE_C - 1)) pause_done <= 1'b1;
         else                             pause_q    <= pause_q + 1'b1;
      end
   end

   // free-running refresh interval, active once initialization is over
   assign tick = run && (ivl_q == IW'(INTERVAL_C - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)    ivl_q <= '0;
      else if (!run) ivl_q <= '0;
      else if (tick) ivl_q <= '0;
      else           ivl_q <= ivl_q + 1'b1;
   end
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
   parameter int MAX_PEND = 8,
   parameter int CNT_W    = $clog2(MAX_PEND + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (cnt != CNT_W'(MAX_PEND)) cnt <= cnt + 1'b1;
            2'b01:   if (cnt != '0)               cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/dram_ref_engine.sv
module dram_ref_engine
   import dram_ref_pkg::*;
#(
   parameter int CSR_C  = 2,
   parameter int CHR_C  = 2,
   parameter int ACT_C  = 14,
   parameter int PRE_C  = 8,
   parameter int INIT_N = 8,
   parameter int PEND_W = 4,
   parameter int ROR_EN = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pause_done,
   input  logic              ref_gnt,
   input  logic [PEND_W-1:0] pend_cnt,
   output logic              ref_req,
   output logic              bus_own,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              init_done,
   output logic              cyc_end
);
   localparam int MAXC = imax(imax(CSR_C, ACT_C), PRE_C);
   localparam int CW   = $clog2(MAXC + 1);
   localparam int NW   = $clog2(INIT_N + 1);

   ref_state_t    state_q;
   logic [CW-1:0] cnt_q;
   logic [NW-1:0] init_q;
   logic          seg_last;

   always_comb begin
      unique case (state_q)
         ST_LEAD: seg_last = (cnt_q == CW'(CSR_C - 1));
         ST_ACT:  seg_last = (cnt_q == CW'(ACT_C - 1));
         ST_PRE:  seg_last = (cnt_q == CW'(PRE_C - 1));
         default: seg_last = 1'b0;
      endcase
   end

   assign cyc_end = (state_q == ST_PRE) && seg_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_PAUSE;
         cnt_q     <= '0;
         init_q    <= '0;
         init_done <= 1'b0;
      end else begin
         unique case (state_q)
            ST_PAUSE: if (pause_done) state_q <= ST_REQ;
            ST_IDLE:  if (pend_cnt != '0) state_q <= ST_REQ;
            ST_REQ: begin
               if (ref_gnt) begin
                  state_q <= ST_LEAD;
                  cnt_q   <= '0;
               end
            end
            ST_LEAD: begin
               if (seg_last) begin
                  state_q <= ST_ACT;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ACT: begin
               if (seg_last) begin
                  state_q <= ST_PRE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PRE: begin
               if (seg_last) begin
                  cnt_q <= '0;
                  if (!init_done) begin
                     // bus is kept for the whole initialization burst
                     if (init_q == NW'(INIT_N - 1)) begin
                        init_done <= 1'b1;
                        state_q   <= ST_IDLE;
                     end else begin
                        init_q  <= init_q + 1'b1;
                        state_q <= ST_LEAD;
                     end
                  end else if ((pend_cnt > PEND_W'(1)) && ref_gnt) begin
                     state_q <= ST_LEAD;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_own = (state_q == ST_LEAD) || (state_q == ST_ACT) || (state_q == ST_PRE);
   assign ref_req = bus_own || (state_q == ST_REQ);
   assign ras_n   = (state_q != ST_ACT);
   assign we_n    = 1'b1;

   generate
      if (ROR_EN != 0) begin : g_ras_only
         assign cas_n = 1'b1;
      end else begin : g_cbr
         assign cas_n = !((state_q == ST_LEAD) ||
                          ((state_q == ST_ACT) && (cnt_q < CW'(CHR_C))));
      end
   endgenerate
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_ref_pkg::*;
#(
   parameter int CLK_NS        = 5,
   parameter int PAUSE_NS      = 100_000,
   parameter int ROWS          = 1024,
   parameter int NORMAL_RET_NS = 16_000_000,
   parameter int LP_RET_NS     = 128_000_000,
   parameter int LOW_POWER     = 0,
   parameter int GUARD_CYC     = 20,
   parameter int INIT_REFRESH  = 8,
   parameter int MAX_PENDING   = 8,
   parameter int T_CSR_NS      = 10,
   parameter int T_CHR_NS      = 10,
   parameter int T_RAS_NS      = 60,
   parameter int T_RC_NS       = 110,
   parameter int T_RP_NS       = 40,
   parameter int T_CPN_NS      = 10,
   parameter int ROR_EN        = 0,
   localparam int ROW_W        = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             ref_req,
   input  logic             ref_gnt,
   output logic             bus_own,
   output logic             ram_ras_n,
   output logic             ram_cas_n,
   output logic             ram_we_n,
   output logic [ROW_W-1:0] ram_row,
   output logic             init_done
);
   localparam int RET_NS     = (LOW_POWER != 0) ? LP_RET_NS : NORMAL_RET_NS;
   localparam int INTERVAL_C = RET_NS / ROWS / CLK_NS - GUARD_CYC;
   localparam int PAUSE_C    = cdiv(PAUSE_NS, CLK_NS);
   localparam int CSR_C      = cdiv(T_CSR_NS, CLK_NS);
   localparam int CHR_C      = cdiv(T_CHR_NS, CLK_NS);
   localparam int ACT_C      = imax(cdiv(T_RAS_NS, CLK_NS), cdiv(T_RC_NS - T_RP_NS, CLK_NS));
   localparam int PRE_C      = imax(cdiv(T_RP_NS, CLK_NS), cdiv(T_CPN_NS, CLK_NS));
   localparam int CYC_C      = CSR_C + ACT_C + PRE_C;
   localparam int PEND_W     = $clog2(MAX_PENDING + 1);

   // elaboration-time parameter checks
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
      if (PAUSE_C < 1) begin : g_bad_pause
         $error("pause must last at least one cycle");
      end
      if (CHR_C >= ACT_C) begin : g_bad_chr
         $error("CAS hold must end before RAS rises");
      end
      if (INTERVAL_C <= CYC_C) begin : g_bad_ivl
         $error("refresh interval shorter than one refresh cycle");
      end
      if (INIT_REFRESH < 1 || MAX_PENDING < 1) begin : g_bad_cnt
         $error("init and backlog counts must be positive");
      end
   endgenerate

   logic              pause_done;
   logic              tick;
   logic              cyc_end;
   logic              served;
   logic [PEND_W-1:0] pend_cnt;

   dram_ref_timer #(
      .PAUSE_C    (PAUSE_C),
      .INTERVAL_C (INTERVAL_C)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (init_done),
      .pause_done (pause_done),
      .tick       (tick)
   );

   // initialization cycles are not taken from the backlog
   assign served = cyc_end && init_done;

   dram_ref_backlog #(
      .MAX_PEND (MAX_PENDING),
      .CNT_W    (PEND_W)
   ) u_backlog (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick),
      .dec   (served),
      .cnt   (pend_cnt)
   );

   dram_ref_engine #(
      .CSR_C  (CSR_C),
      .CHR_C  (CHR_C),
      .ACT_C  (ACT_C),
      .PRE_C  (PRE_C),
      .INIT_N (INIT_REFRESH),
      .PEND_W (PEND_W),
      .ROR_EN (ROR_EN)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .pause_done (pause_done),
      .ref_gnt    (ref_gnt),
      .pend_cnt   (pend_cnt),
      .ref_req    (ref_req),
      .bus_own    (bus_own),
      .ras_n      (ram_ras_n),
      .cas_n      (ram_cas_n),
      .we_n       (ram_we_n),
      .init_done  (init_done),
      .cyc_end    (cyc_end)
   );

   generate
      if (ROR_EN != 0) begin : g_row_ctr
         logic [ROW_W-1:0] row_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                           row_q <= '0;
            else if (cyc_end && row_q == ROW_W'(ROWS - 1)) row_q <= '0;
            else if (cyc_end)                     row_q <= row_q + 1'b1;
         end
         assign ram_row = row_q;
      end else begin : g_no_row
         assign ram_row = '0;
      end
   endgenerate
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
   parameter int PAUSE_C = 20000,
   parameter int CSR_C   = 2,
   parameter int CHR_C   = 2,
   parameter int ACT_C   = 14,
   parameter int PRE_C   = 8,
   parameter int INIT_N  = 8,
   parameter int ROR_EN  = 0
) (
   input logic clk,
   input logic rst_n,
   input logic ref_req,
   input logic ref_gnt,
   input logic bus_own,
   input logic ram_ras_n,
   input logic ram_cas_n,
   input logic init_done
);
   localparam int CAP = 1 << 30;

   int pause_cnt, cas_lo, ras_lo, ras_hi, falls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pause_cnt <= 0;
         cas_lo    <= 0;
         ras_lo    <= 0;
         ras_hi    <= PRE_C;
         falls     <= 0;
      end else begin
         if (pause_cnt < CAP) pause_cnt <= pause_cnt + 1;
         cas_lo <= ram_cas_n ? 0 : ((cas_lo < CAP) ? cas_lo + 1 : cas_lo);
         ras_lo <= ram_ras_n ? 0 : ((ras_lo < CAP) ? ras_lo + 1 : ras_lo);
         ras_hi <= !ram_ras_n ? 0 : ((ras_hi < CAP) ? ras_hi + 1 : ras_hi);
         if ($fell(ram_ras_n) && falls < CAP) falls <= falls + 1;
      end
   end

   assert_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_cnt < PAUSE_C) |-> !ref_req);

   assert_init_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (falls == INIT_N));

   assert_init_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_req) |-> init_done);

   assert_pins_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_own |-> (ram_ras_n && ram_cas_n));

   assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_ras_n) |-> (ras_lo >= ACT_C));

   assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_ras_n) |-> (ras_hi >= PRE_C));

   assert_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_own) |-> $past(ref_gnt));

   generate
      if (ROR_EN == 0) begin : g_cbr_chk
         assert_cas_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ram_ras_n) |-> (cas_lo >= CSR_C));
         assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ram_cas_n) && !ram_ras_n) |-> (ras_lo >= CHR_C));
      end else begin : g_ror_chk
         assert_cas_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
            bus_own |-> ram_cas_n);
      end
   endgenerate
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
   .PAUSE_C (PAUSE_C),
   .CSR_C   (CSR_C),
   .CHR_C   (CHR_C),
   .ACT_C   (ACT_C),
   .PRE_C   (PRE_C),
   .INIT_N  (INIT_REFRESH),
   .ROR_EN  (ROR_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_req   (ref_req),
   .ref_gnt   (ref_gnt),
   .bus_own   (bus_own),
   .ram_ras_n (ram_ras_n),
   .ram_cas_n (ram_cas_n),
   .init_done (init_done)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps

module tb_ref_mon #(
   parameter int CSR = 2,
   parameter int CHR = 2,
   parameter int ACT = 14,
   parameter int PRE = 8,
   parameter int ROR = 0
) (
   input logic clk,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic own
);
   int nchk = 0, nerr = 0, falls = 0;
   int cas_lo = 0, ras_lo = 0, ras_hi = 1000;
   logic ras_p = 1'b1, cas_p = 1'b1;

   task automatic mchk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %m actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (ras_p && !ras_n) begin
         falls++;
         if (ROR == 0) mchk(cas_lo >= CSR, "R4 CAS lead cycles", cas_lo, CSR);
         else          mchk(cas_n == 1'b1, "R11 CAS high at RAS fall", int'(cas_n), 1);
         mchk(ras_hi >= PRE, "R6 precharge cycles", ras_hi, PRE);
         mchk(we_n == 1'b1, "R5 WE high at RAS fall", int'(we_n), 1);
      end
      if (!ras_p && ras_n) mchk(ras_lo >= ACT, "R6 RAS low cycles", ras_lo, ACT);
      if (!cas_p && cas_n && !ras_n) mchk(ras_lo >= CHR, "R4 CAS hold cycles", ras_lo, CHR);
      if (own && !we_n) mchk(1'b0, "R5 WE low while owning", 0, 1);
      if (!own && !(ras_n && cas_n)) mchk(1'b0, "R5 strobe active without ownership", 0, 1);
      if (ROR != 0 && own && !cas_n) mchk(1'b0, "R11 CAS low in RAS-only mode", 0, 1);
      cas_lo = cas_n ? 0 : cas_lo + 1;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      ras_p  = ras_n;
      cas_p  = cas_n;
   end
endmodule

module dram_refresh_seq_tb;
   localparam int CLK   = 5;
   localparam int PAUSE = 40;
   localparam int IV_N  = 300;
   localparam int IV_LP = 604;
   localparam int IV_R  = 36;
   localparam int RET_N = 1024 * CLK * (IV_N + 4);
   localparam int RET_L = 1024 * CLK * (IV_LP + 4);
   localparam int RET_R = 16 * CLK * (IV_R + 4);
   localparam int CSR   = 2;
   localparam int CHR   = 2;
   localparam int ACT   = 14;
   localparam int PRE   = 8;
   localparam int NINIT = 8;
   localparam int NPEND = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int nchk = 0, nerr = 0, cyc = 0;
   always @(posedge clk) cyc++;

   // main instance
   logic gnt_force = 1'b0, auto_gnt = 1'b0;
   logic req_m, own_m, ras_m, cas_m, we_m, done_m;
   logic [9:0] row_m;
   logic gnt_m;
   assign gnt_m = auto_gnt ? req_m : gnt_force;

   dram_refresh_seq #(
      .CLK_NS(CLK), .PAUSE_NS(PAUSE * CLK), .ROWS(1024), .NORMAL_RET_NS(RET_N),
      .LP_RET_NS(RET_L), .LOW_POWER(0), .GUARD_CYC(4), .INIT_REFRESH(NINIT),
      .MAX_PENDING(NPEND), .ROR_EN(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_req(req_m), .ref_gnt(gnt_m), .bus_own(own_m),
      .ram_ras_n(ras_m), .ram_cas_n(cas_m), .ram_we_n(we_m), .ram_row(row_m),
      .init_done(done_m)
   );

   // low-power instance, granted on demand
   logic req_l, own_l, ras_l, cas_l, we_l, done_l;
   logic [9:0] row_l;

   dram_refresh_seq #(
      .CLK_NS(CLK), .PAUSE_NS(PAUSE * CLK), .ROWS(1024), .NORMAL_RET_NS(RET_N),
      .LP_RET_NS(RET_L), .LOW_POWER(1), .GUARD_CYC(4), .INIT_REFRESH(NINIT),
      .MAX_PENDING(NPEND), .ROR_EN(0)
   ) u_dut_lp (
      .clk(clk), .rst_n(rst_n), .ref_req(req_l), .ref_gnt(req_l), .bus_own(own_l),
      .ram_ras_n(ras_l), .ram_cas_n(cas_l), .ram_we_n(we_l), .ram_row(row_l),
      .init_done(done_l)
   );

   // RAS-only instance with 16 rows
   logic req_r, own_r, ras_r, cas_r, we_r, done_r;
   logic [3:0] row_r;

   dram_refresh_seq #(
      .CLK_NS(CLK), .PAUSE_NS(PAUSE * CLK), .ROWS(16), .NORMAL_RET_NS(RET_R),
      .LP_RET_NS(RET_R), .LOW_POWER(0), .GUARD_CYC(4), .INIT_REFRESH(NINIT),
      .MAX_PENDING(NPEND), .ROR_EN(1)
   ) u_dut_ror (
      .clk(clk), .rst_n(rst_n), .ref_req(req_r), .ref_gnt(req_r), .bus_own(own_r),
      .ram_ras_n(ras_r), .ram_cas_n(cas_r), .ram_we_n(we_r), .ram_row(row_r),
      .init_done(done_r)
   );

   tb_ref_mon #(.CSR(CSR), .CHR(CHR), .ACT(ACT), .PRE(PRE), .ROR(0)) u_mon_m
      (.clk(clk), .ras_n(ras_m), .cas_n(cas_m), .we_n(we_m), .own(own_m));
   tb_ref_mon #(.CSR(CSR), .CHR(CHR), .ACT(ACT), .PRE(PRE), .ROR(0)) u_mon_l
      (.clk(clk), .ras_n(ras_l), .cas_n(cas_l), .we_n(we_l), .own(own_l));
   tb_ref_mon #(.CSR(CSR), .CHR(CHR), .ACT(ACT), .PRE(PRE), .ROR(1)) u_mon_r
      (.clk(clk), .ras_n(ras_r), .cas_n(cas_r), .we_n(we_r), .own(own_r));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      int c, e;
      c = nchk + u_mon_m.nchk + u_mon_l.nchk + u_mon_r.nchk;
      e = nerr + u_mon_m.nerr + u_mon_l.nerr + u_mon_r.nerr;
      $display("CHECKS %0d ERRORS %0d", c, e);
   endtask

   // R11: RAS-only row address sequence, including the wrap from 15 to 0
   int  ror_seen = 0;
   logic ror_ras_p = 1'b1;
   always @(negedge clk) begin
      if (rst_n && ror_ras_p && !ras_r && ror_seen < 40) begin
         check(int'(row_r) == ror_seen % 16, "R11 row address", int'(row_r), ror_seen % 16);
         ror_seen++;
      end
      ror_ras_p = ras_r;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      report();
      $finish;
   end

   initial begin
      int c, drops, t0, t1, f0, n, exp;

      repeat (4) @(posedge clk);
      @(negedge clk);
      check(ras_m && cas_m && we_m && !done_m && !req_m && !own_m,
            "R5 reset state", {ras_m, cas_m, we_m, done_m, req_m, own_m}, 6'b111000);
      rst_n = 1'b1;

      // R1: pause length
      c = 0;
      while (!req_m && c < 1000) begin
         @(negedge clk);
         c++;
      end
      check(c >= PAUSE && c <= PAUSE + 2, "R1 cycles until first request", c, PAUSE + 1);

      // R9: grant withheld, nothing may move
      repeat (20) @(negedge clk);
      check(u_mon_m.falls == 0 && !own_m && req_m, "R9 idle while grant withheld",
            u_mon_m.falls, 0);

      // R2, R3: initialization burst under one grant
      gnt_force = 1'b1;
      drops = 0;
      c = 0;
      @(negedge clk);
      while (!done_m && c < 2000) begin
         if (!own_m || !req_m) drops++;
         @(negedge clk);
         c++;
      end
      check(u_mon_m.falls == NINIT, "R2 refresh count before init_done", u_mon_m.falls, NINIT);
      check(drops == 0, "R3 bus kept during initialization", drops, 0);
      check(!own_m && !req_m, "R3 bus released at init_done", {own_m, req_m}, 0);
      gnt_force = 1'b0;

      // R7: interval with the grant always given
      auto_gnt = 1'b1;
      while (!req_m) @(negedge clk);
      t0 = cyc;
      for (int i = 0; i < 3; i++) begin
         while (req_m) @(negedge clk);
         while (!req_m) @(negedge clk);
         t1 = cyc;
         check(t1 - t0 == IV_N, "R7 normal refresh interval", t1 - t0, IV_N);
         t0 = t1;
      end
      while (req_m) @(negedge clk);
      auto_gnt = 1'b0;

      // R10: backlog sweep, 1 to 10 intervals without a grant
      for (int k = 1; k <= 10; k++) begin
         while (req_m) @(negedge clk);
         while (!req_m) @(negedge clk);
         repeat ((k - 1) * IV_N + 10) @(negedge clk);
         f0 = u_mon_m.falls;
         gnt_force = 1'b1;
         @(negedge clk);
         drops = 0;
         c = 0;
         while (req_m && c < 5000) begin
            if (!own_m) drops++;
            @(negedge clk);
            c++;
         end
         gnt_force = 1'b0;
         n = u_mon_m.falls - f0;
         exp = (k < NPEND) ? k : NPEND;
         check(n == exp, "R10 refreshes run after backlog", n, exp);
         check(drops == 0, "R10 backlog run back to back", drops, 0);
      end

      // R8: low-power interval
      while (!req_l) @(negedge clk);
      t0 = cyc;
      for (int i = 0; i < 2; i++) begin
         while (req_l) @(negedge clk);
         while (!req_l) @(negedge clk);
         t1 = cyc;
         check(t1 - t0 == IV_LP, "R8 low-power refresh interval", t1 - t0, IV_LP);
         t0 = t1;
      end
      check(done_l && done_r, "R2 init_done on side instances", {done_l, done_r}, 2'b11);
      check(ror_seen >= 17, "R11 row wrap reached", ror_seen, 17);

      repeat (5) @(negedge clk);
      report();
      $finish;
   end
endmodule